// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the control side of a byte-wide flash memory model. It observes synchronous write cycles, each an address and a data byte, and tracks the unlock-prefixed command sequences that a host issues: byte program, chip erase, permanent lock of the low boot sector, and entry to and exit from an identification mode. When a program or erase sequence completes, it emits a one-cycle start pulse for the operation timer and holds the target address and data on its outputs.

The decoder keeps two flags: the identification-mode flag and a sticky boot-lock flag. While the lock is set, program requests aimed at the low boot sector are dropped, and the array side reads the lock output to keep that sector intact during an erase. In identification mode a small read-back path answers reads of the three lowest addresses with a manufacturer code, a device code and the lock flag. Writes are ignored while the operation timer reports busy, or while a write-inhibit input (low supply or output enable held active) is asserted.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the decoder is idle, `id_mode` and `boot_locked` are 0 and neither `prog_start` nor `erase_start` is high.
- R2: The write sequence AA to 5555h, 55 to 2AAAh, A0 to 5555h, then data D to address A makes `prog_start` high for exactly the one cycle after the fourth write is clocked, with `op_addr` = A and `op_data` = D.
- R3: The write sequence AA/5555h, 55/2AAAh, 80/5555h, AA/5555h, 55/2AAAh, 10/5555h makes `erase_start` high for the one cycle after the sixth write; it does so whether or not the boot lock is set.
- R4: The same six-cycle sequence ending in 40/5555h sets `boot_locked` in the cycle after the last write; no command clears it, only reset.
- R5: While `boot_locked` is 1, the final program write to any address below 2000h produces no `prog_start`; a program write to address 2000h or above still produces it.
- R6: Command addresses are matched on the low 15 address bits only (address bits 17..15 are don't-care for 5555h and 2AAAh).
- R7: AA/5555h, 55/2AAAh, 90/5555h sets `id_mode`; it is cleared either by AA/5555h, 55/2AAAh, F0/5555h, or by one write of F0 to any address while no sequence is in progress.
- R8: With `id_mode` = 1, `rd_addr` 0 gives `id_hit`=1 and `id_data`=1Fh, 1 gives 0Bh, 2 gives `boot_locked` on bit 0 and zeros elsewhere; any other `rd_addr` (including ones with high bits set) or `id_mode`=0 gives `id_hit`=0 and `id_data`=00h.
- R9: A write that does not match the next expected cycle abandons the sequence and is decoded as if the decoder were idle, so AA/5555h at that point starts a new sequence and any other write starts nothing.
- R10: A write presented while `op_busy` is 1 is ignored: it causes no pulse and leaves the sequence position and flags unchanged.
- R11: A write presented while `wr_inhibit` is 1 is ignored in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per bus write |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data byte |
| wr_inhibit | input | 1 | Suppresses command recognition |
| op_busy | input | 1 | Program or erase in progress |
| rd_addr | input | 18 | Read address for identification read-back |
| prog_start | output | 1 | One-cycle byte program start |
| erase_start | output | 1 | One-cycle chip erase start |
| op_addr | output | 18 | Latched program address |
| op_data | output | 8 | Latched program data |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot sector lock (sticky) |
| id_hit | output | 1 | Read address answered by identification data |
| id_data | output | 8 | Identification read-back byte |

## Verification
The main decoding is driven with every complete command, with prefixes whose command addresses carry set high bits, and with sequences broken by a wrong data byte or by a repeated first unlock cycle, which separates a decoder that restarts on AA from one that only drops to idle. Program targets sit on both sides of the 2000h boundary before and after the lock is set, so a wrong boundary or an unguarded program path shows up as a stray or missing pulse. Busy and inhibited writes are inserted in the middle of a sequence, and the sequence is then completed, which tells apart a write that was ignored from one that reset or advanced the decoder.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_UNLOCK1  = 8'hAA;
    localparam logic [BYTE_W-1:0] CODE_UNLOCK2  = 8'h55;
    localparam logic [BYTE_W-1:0] CODE_PROG     = 8'hA0;
    localparam logic [BYTE_W-1:0] CODE_ER_SETUP = 8'h80;
    localparam logic [BYTE_W-1:0] CODE_ID_ENTER = 8'h90;
    localparam logic [BYTE_W-1:0] CODE_ID_EXIT  = 8'hF0;
    localparam logic [BYTE_W-1:0] CODE_ER_GO    = 8'h10;
    localparam logic [BYTE_W-1:0] CODE_LOCK_GO  = 8'h40;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_UNL1 = 3'd1,
        PH_UNL2 = 3'd2,
        PH_ER3  = 3'd3,
        PH_ER4  = 3'd4,
        PH_ER5  = 3'd5,
        PH_PGM  = 3'd6
    } phase_e;

    typedef struct packed {
        logic hit_a1;
        logic hit_a2;
        logic d_unlock1;
        logic d_unlock2;
        logic d_prog;
        logic d_er_setup;
        logic d_id_enter;
        logic d_id_exit;
        logic d_er_go;
        logic d_lock_go;
        logic in_boot;
    } cyc_flags_t;

endpackage

// File: rtl/fcs_cycle_match.sv
module fcs_cycle_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CMP_W  = 15,
    parameter int BOOT_W = 13,
    parameter logic [CMP_W-1:0] KEY_A1 = 15'h5555,
    parameter logic [CMP_W-1:0] KEY_A2 = 15'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output cyc_flags_t        flags
);

    logic boot_hit;

    generate
        if (BOOT_W < ADDR_W) begin : g_boot_cmp
            assign boot_hit = ~|addr[ADDR_W-1:BOOT_W];
        end else begin : g_boot_all
            assign boot_hit = 1'b1;
        end
    endgenerate

    always_comb begin
        flags            = '0;
        flags.hit_a1     = (addr[CMP_W-1:0] == KEY_A1);
        flags.hit_a2     = (addr[CMP_W-1:0] == KEY_A2);
        flags.d_unlock1  = (data == CODE_UNLOCK1);
        flags.d_unlock2  = (data == CODE_UNLOCK2);
        flags.d_prog     = (data == CODE_PROG);
        flags.d_er_setup = (data == CODE_ER_SETUP);
        flags.d_id_enter = (data == CODE_ID_ENTER);
        flags.d_id_exit  = (data == CODE_ID_EXIT);
        flags.d_er_go    = (data == CODE_ER_GO);
        flags.d_lock_go  = (data == CODE_LOCK_GO);
        flags.in_boot    = boot_hit;
    end

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_inhibit,
    input  logic              op_busy,
    input  cyc_flags_t        flags,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTE_W-1:0] op_data,
    output logic              id_mode,
    output logic              boot_locked
);

    typedef struct packed {
        phase_e            phase;
        logic              id_mode;
        logic              locked;
        logic              prog_go;
        logic              erase_go;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    accept;
    logic    fall_back;
    phase_e  idle_phase;

    always_comb begin
        accept      = wr_en && !wr_inhibit && !op_busy;
        idle_phase  = (flags.hit_a1 && flags.d_unlock1) ? PH_UNL1 : PH_IDLE;
        st_d        = st_q;
        st_d.prog_go  = 1'b0;
        st_d.erase_go = 1'b0;
        fall_back   = 1'b0;

        if (accept) begin
            fall_back = 1'b1;
            case (st_q.phase)
                PH_UNL1: begin
                    if (flags.hit_a2 && flags.d_unlock2) begin
                        st_d.phase = PH_UNL2;
                        fall_back  = 1'b0;
                    end
                end
                PH_UNL2: begin
                    if (flags.hit_a1) begin
                        if (flags.d_prog) begin
                            st_d.phase = PH_PGM;
                            fall_back  = 1'b0;
                        end else if (flags.d_er_setup) begin
                            st_d.phase = PH_ER3;
                            fall_back  = 1'b0;
                        end else if (flags.d_id_enter) begin
                            st_d.phase   = PH_IDLE;
                            st_d.id_mode = 1'b1;
                            fall_back    = 1'b0;
                        end else if (flags.d_id_exit) begin
                            st_d.phase   = PH_IDLE;
                            st_d.id_mode = 1'b0;
                            fall_back    = 1'b0;
                        end
                    end
                end
                PH_ER3: begin
                    if (flags.hit_a1 && flags.d_unlock1) begin
                        st_d.phase = PH_ER4;
                        fall_back  = 1'b0;
                    end
                end
                PH_ER4: begin
                    if (flags.hit_a2 && flags.d_unlock2) begin
                        st_d.phase = PH_ER5;
                        fall_back  = 1'b0;
                    end
                end
                PH_ER5: begin
                    if (flags.hit_a1 && flags.d_er_go) begin
                        st_d.phase    = PH_IDLE;
                        st_d.erase_go = 1'b1;
                        fall_back     = 1'b0;
                    end else if (flags.hit_a1 && flags.d_lock_go) begin
                        st_d.phase  = PH_IDLE;
                        st_d.locked = 1'b1;
                        fall_back   = 1'b0;
                    end
                end
                PH_PGM: begin
                    st_d.phase = PH_IDLE;
                    fall_back  = 1'b0;
                    if (!(st_q.locked && flags.in_boot)) begin
                        st_d.prog_go = 1'b1;
                        st_d.addr    = wr_addr;
                        st_d.data    = wr_data;
                    end
                end
                default: ;
            endcase

            if (fall_back) begin
                st_d.phase = idle_phase;
                if (flags.d_id_exit) begin
                    st_d.id_mode = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_start  = st_q.prog_go;
    assign erase_start = st_q.erase_go;
    assign op_addr     = st_q.addr;
    assign op_data     = st_q.data;
    assign id_mode     = st_q.id_mode;
    assign boot_locked = st_q.locked;

endmodule

// File: rtl/fcs_id_read.sv
module fcs_id_read
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'h1F,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'h0B
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              id_mode,
    input  logic              boot_locked,
    output logic              id_hit,
    output logic [BYTE_W-1:0] id_data
);

    logic upper_zero;

    assign upper_zero = ~|rd_addr[ADDR_W-1:2];

    always_comb begin
        id_hit  = 1'b0;
        id_data = '0;
        if (id_mode && upper_zero) begin
            case (rd_addr[1:0])
                2'd0: begin
                    id_hit  = 1'b1;
                    id_data = MFR_CODE;
                end
                2'd1: begin
                    id_hit  = 1'b1;
                    id_data = DEV_CODE;
                end
                2'd2: begin
                    id_hit  = 1'b1;
                    id_data = {{(BYTE_W-1){1'b0}}, boot_locked};
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CMP_W  = 15,
    parameter int BOOT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_inhibit,
    input  logic              op_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode,
    output logic              boot_locked,
    output logic              id_hit,
    output logic [7:0]        id_data
);

    cyc_flags_t cyc_flags;

    fcs_cycle_match #(
        .ADDR_W (ADDR_W),
        .CMP_W  (CMP_W),
        .BOOT_W (BOOT_W)
    ) match_i (
        .addr  (wr_addr),
        .data  (wr_data),
        .flags (cyc_flags)
    );

    fcs_seq_fsm #(
        .ADDR_W (ADDR_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_inhibit  (wr_inhibit),
        .op_busy     (op_busy),
        .flags       (cyc_flags),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .id_mode     (id_mode),
        .boot_locked (boot_locked)
    );

    fcs_id_read #(
        .ADDR_W (ADDR_W)
    ) idrd_i (
        .rd_addr     (rd_addr),
        .id_mode     (id_mode),
        .boot_locked (boot_locked),
        .id_hit      (id_hit),
        .id_data     (id_data)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int BOOT_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_inhibit,
    input logic              op_busy,
    input logic              prog_start,
    input logic              erase_start,
    input logic [ADDR_W-1:0] op_addr,
    input logic              id_mode,
    input logic              boot_locked,
    input logic              id_hit
);

    localparam logic [ADDR_W:0] BOOT_END = (ADDR_W+1)'(1) << BOOT_W;

    AST_ONE_OP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start && erase_start)); // R3

    AST_NO_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!prog_start && !erase_start)); // R2

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked); // R4

    AST_BOOT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && boot_locked) |-> ({1'b0, op_addr} >= BOOT_END)); // R5

    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |=> (!prog_start && !erase_start
                     && $stable(id_mode) && $stable(boot_locked))); // R10

    AST_INHIBIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |=> (!prog_start && !erase_start
                        && $stable(id_mode) && $stable(boot_locked))); // R11

    AST_ID_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |-> id_mode); // R8

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .ADDR_W (ADDR_W),
    .BOOT_W (BOOT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_inhibit  (wr_inhibit),
    .op_busy     (op_busy),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .op_addr     (op_addr),
    .id_mode     (id_mode),
    .boot_locked (boot_locked),
    .id_hit      (id_hit)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_inhibit = 1'b0;
    logic        op_busy = 1'b0;
    logic [17:0] rd_addr = '0;
    logic        prog_start, erase_start, id_mode, boot_locked, id_hit;
    logic [17:0] op_addr;
    logic [7:0]  op_data, id_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_inhibit (wr_inhibit), .op_busy (op_busy),
        .rd_addr (rd_addr), .prog_start (prog_start), .erase_start (erase_start),
        .op_addr (op_addr), .op_data (op_data), .id_mode (id_mode),
        .boot_locked (boot_locked), .id_hit (id_hit), .id_data (id_data)
    );

    // entry: {tag, addr, data, exp prog, exp erase, exp id_mode, exp lock}
    localparam int NV = 29;
    localparam logic [33:0] VEC [NV] = '{
        {4'd2, 18'h05555, 8'hAA, 4'b0000},  // R2 program
        {4'd2, 18'h02AAA, 8'h55, 4'b0000},
        {4'd2, 18'h05555, 8'hA0, 4'b0000},
        {4'd2, 18'h01234, 8'h3C, 4'b1000},
        {4'd6, 18'h25555, 8'hAA, 4'b0000},  // R6 high bits ignored, R3 erase
        {4'd6, 18'h12AAA, 8'h55, 4'b0000},
        {4'd3, 18'h05555, 8'h80, 4'b0000},
        {4'd3, 18'h05555, 8'hAA, 4'b0000},
        {4'd3, 18'h02AAA, 8'h55, 4'b0000},
        {4'd3, 18'h05555, 8'h10, 4'b0100},
        {4'd7, 18'h05555, 8'hAA, 4'b0000},  // R7 entry, single exit
        {4'd7, 18'h02AAA, 8'h55, 4'b0000},
        {4'd7, 18'h05555, 8'h90, 4'b0010},
        {4'd7, 18'h3FFFF, 8'hF0, 4'b0000},
        {4'd7, 18'h05555, 8'hAA, 4'b0000},  // R7 entry, 3-cycle exit
        {4'd7, 18'h02AAA, 8'h55, 4'b0000},
        {4'd7, 18'h05555, 8'h90, 4'b0010},
        {4'd7, 18'h05555, 8'hAA, 4'b0010},
        {4'd7, 18'h02AAA, 8'h55, 4'b0010},
        {4'd7, 18'h05555, 8'hF0, 4'b0000},
        {4'd9, 18'h05555, 8'hAA, 4'b0000},  // R9 wrong data drops sequence
        {4'd9, 18'h02AAA, 8'h77, 4'b0000},
        {4'd9, 18'h05555, 8'hA0, 4'b0000},
        {4'd9, 18'h00400, 8'h12, 4'b0000},
        {4'd9, 18'h05555, 8'hAA, 4'b0000},  // R9 repeated AA restarts
        {4'd9, 18'h05555, 8'hAA, 4'b0000},
        {4'd9, 18'h02AAA, 8'h55, 4'b0000},
        {4'd9, 18'h05555, 8'hA0, 4'b0000},
        {4'd9, 18'h30000, 8'h5A, 4'b1000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic flags_now(input string tag, input logic [3:0] exp);
        chk(tag, 32'({prog_start, erase_start, id_mode, boot_locked}), 32'(exp));
    endtask

    task automatic unlock_pair();
        do_wr(18'h05555, 8'hAA);
        do_wr(18'h02AAA, 8'h55);
    endtask

    initial begin
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        flags_now("R1 reset flags", 4'b0000);
        chk("R1 reset id_hit", 32'(id_hit), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i][29:12], VEC[i][11:4]);
            flags_now($sformatf("R%0d vector %0d", VEC[i][33:30], i), VEC[i][3:0]);
            if (VEC[i][3]) begin
                chk($sformatf("R2 op_addr vector %0d", i), 32'(op_addr), 32'(VEC[i][29:12]));
                chk($sformatf("R2 op_data vector %0d", i), 32'(op_data), 32'(VEC[i][11:4]));
            end
        end

        // R2: pulse lasts only one cycle
        do_wr(18'h05555, 8'hAA); do_wr(18'h02AAA, 8'h55); do_wr(18'h05555, 8'hA0);
        do_wr(18'h02000, 8'h81);
        chk("R2 pulse present", 32'(prog_start), 32'd1);
        @(negedge clk);
        chk("R2 pulse one cycle", 32'(prog_start), 32'd0);

        // R8: read-back with mode off, then on
        rd_addr = 18'h00000; #1;
        chk("R8 mode off no hit", 32'({id_hit, id_data}), 32'h000);
        unlock_pair(); do_wr(18'h05555, 8'h90);
        rd_addr = 18'h00000; #1;
        chk("R8 manufacturer", 32'({id_hit, id_data}), 32'h11F);
        rd_addr = 18'h00001; #1;
        chk("R8 device", 32'({id_hit, id_data}), 32'h10B);
        rd_addr = 18'h00002; #1;
        chk("R8 lock bit clear", 32'({id_hit, id_data}), 32'h100);
        rd_addr = 18'h00003; #1;
        chk("R8 addr 3 no hit", 32'({id_hit, id_data}), 32'h000);
        rd_addr = 18'h20001; #1;
        chk("R8 high bit no hit", 32'({id_hit, id_data}), 32'h000);
        do_wr(18'h00000, 8'hF0);

        // R10: busy write mid-sequence ignored, sequence continues
        unlock_pair();
        op_busy = 1'b1;
        do_wr(18'h00000, 8'h77);
        op_busy = 1'b0;
        do_wr(18'h05555, 8'hA0);
        do_wr(18'h04321, 8'hC3);
        chk("R10 sequence survives busy", 32'({prog_start, op_addr, op_data}), 32'({1'b1, 18'h04321, 8'hC3}));
        unlock_pair(); do_wr(18'h05555, 8'hA0);
        op_busy = 1'b1;
        do_wr(18'h04444, 8'h11);
        op_busy = 1'b0;
        chk("R10 no pulse while busy", 32'(prog_start), 32'd0);
        do_wr(18'h04444, 8'h22);
        chk("R10 data write after busy", 32'({prog_start, op_data}), 32'({1'b1, 8'h22}));

        // R11: inhibited write ignored
        unlock_pair(); do_wr(18'h05555, 8'hA0);
        wr_inhibit = 1'b1;
        do_wr(18'h00000, 8'h00);
        wr_inhibit = 1'b0;
        chk("R11 no pulse inhibited", 32'(prog_start), 32'd0);
        do_wr(18'h05000, 8'h66);
        chk("R11 sequence survives inhibit", 32'({prog_start, op_addr, op_data}), 32'({1'b1, 18'h05000, 8'h66}));
        wr_inhibit = 1'b1;
        unlock_pair(); do_wr(18'h05555, 8'h90);
        wr_inhibit = 1'b0;
        chk("R11 id entry inhibited", 32'(id_mode), 32'd0);

        // R4: lock set
        unlock_pair(); do_wr(18'h05555, 8'h80);
        unlock_pair(); do_wr(18'h05555, 8'h40);
        flags_now("R4 lock set", 4'b0001);

        // R5: boot region blocked, boundary allowed
        unlock_pair(); do_wr(18'h05555, 8'hA0);
        do_wr(18'h01FFF, 8'h00);
        chk("R5 boot top blocked", 32'(prog_start), 32'd0);
        unlock_pair(); do_wr(18'h05555, 8'hA0);
        do_wr(18'h00000, 8'h00);
        chk("R5 boot base blocked", 32'(prog_start), 32'd0);
        unlock_pair(); do_wr(18'h05555, 8'hA0);
        do_wr(18'h02000, 8'h9E);
        chk("R5 boundary allowed", 32'({prog_start, op_addr, op_data}), 32'({1'b1, 18'h02000, 8'h9E}));

        // R3: erase still issued with lock; R4 lock survives commands
        unlock_pair(); do_wr(18'h05555, 8'h80);
        unlock_pair(); do_wr(18'h05555, 8'h10);
        flags_now("R3 erase with lock", 4'b0101);
        do_wr(18'h00000, 8'hF0);
        unlock_pair(); do_wr(18'h05555, 8'hF0);
        flags_now("R4 lock survives exits", 4'b0001);

        // R8: lock visible in read-back
        unlock_pair(); do_wr(18'h05555, 8'h90);
        rd_addr = 18'h00002; #1;
        chk("R8 lock bit set", 32'({id_hit, id_data}), 32'h101);

        // R1: reset clears flags
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        flags_now("R1 flags after reset", 4'b0000);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule